// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps the per-port traffic statistics of an Ethernet MAC. The receive and transmit datapaths each deliver a one-cycle status event per finished frame. The event carries the frame length and flags for address class (multicast, broadcast), pause, and errors. From these the block keeps byte and frame totals, per-type counts, a seven-bucket length histogram for each direction, and a counter of received frames longer than a programmed maximum.

Software reads the counters through a simple word-addressed read port. Every read clears the counter it returns, so software accumulates deltas. The wide byte and frame totals are read as a low/high word pair. Reading the low word snapshots the upper bits into a shadow register and clears the whole counter. A later high-word read returns that snapshot. A single global clear input zeroes everything at once. Counters stop at all ones instead of wrapping. An event that lands in the same cycle as the clearing read of its counter is never lost.

Top module: `mac_stat_counters`

## Requirements
- R1: After reset, every counter and every shadow register reads 0. While `clr_all` is high, all counters and shadows become 0 at the next edge, and any event in that same cycle is discarded.
- R2: A read with `rd_en` high in a cycle loads `rd_data` at that clock edge with the pre-edge value of the addressed word. `rd_data` then holds until the next read. Word addresses (hex) are: receive bytes low/high 00/01, receive frames low/high 02/03, receive per-type counters 04..0B, max-size error 0C, receive histogram 10..16, transmit bytes low/high 20/21, transmit frames low/high 22/23, transmit per-type counters 24..27, transmit histogram 30..36. Every other address reads 0 and clears nothing.
- R3: A read of a counter (or of a pair's low word) clears it. If an event increments that counter in the same cycle, the counter reloads with that cycle's increment instead of 0.
- R4: A low-word read of a pair returns count bits 31:0, copies the upper count bits into the pair's shadow register and clears the whole counter. A high-word read returns the shadow (zero-extended) and changes nothing.
- R5: Each receive or transmit event adds its length to the byte counter of its direction (45 bits by default) and 1 to the frame total (40 bits by default).
- R6: Each event increments exactly one histogram bucket of its direction. Bucket offsets 0..6 cover lengths of at most 64, 65-127, 128-255, 256-511, 512-1023, 1024-1518, and 1519 or more.
- R7: Receive per-type offsets from 04 are: 0 multicast flag, 1 broadcast flag, 2 FCS error flag, 3 pause flag, 4 jabber (length above 1518 with FCS error), 5 short (length below 64), 6 symbol error flag, 7 oversize (length above 1518 with good FCS).
- R8: Word 0C bits 30:0 count received frames whose length exceeds `max_pkt_len`. Bit 31 returns `rx_fifo_empty` as sampled in the read cycle.
- R9: Transmit per-type offsets from 24 are: 0 multicast, 1 broadcast, 2 pause, 3 errored frame (`tx_err`, any cause).
- R10: Every counter saturates at all ones. Per-type and histogram counters are `CNT_W` bits wide, and the max-size error counter is `CNT_W`-1 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_all | input | 1 | Global clear of all counters and shadows |
| rx_evt | input | 1 | Receive frame status valid (one cycle per frame) |
| rx_len | input | LEN_W | Received frame length in bytes |
| rx_fcs_err | input | 1 | Received frame had a bad FCS |
| rx_sym_err | input | 1 | Received frame had a symbol/code error |
| rx_pause | input | 1 | Received frame was a pause frame |
| rx_mcast | input | 1 | Received frame had a multicast destination |
| rx_bcast | input | 1 | Received frame had a broadcast destination |
| max_pkt_len | input | LEN_W | Programmed maximum receive length |
| rx_fifo_empty | input | 1 | Receive FIFO empty indication, reported in bit 31 of word 0C |
| tx_evt | input | 1 | Transmit frame status valid (one cycle per frame) |
| tx_len | input | LEN_W | Transmitted frame length in bytes |
| tx_err | input | 1 | Transmitted frame was errored (bad FCS, underrun or other) |
| tx_pause | input | 1 | Transmitted frame was a pause frame |
| tx_mcast | input | 1 | Transmitted frame had a multicast destination |
| tx_bcast | input | 1 | Transmitted frame had a broadcast destination |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Registered read data |

## Verification
The hardest states to reach from the ports are the high half of a wide pair, which needs more than four billion bytes, and the saturation ceiling of the 32-bit counters. The bench widens the length field to 24 bits so that a few hundred large frames carry the receive byte count over 2^32. It then interleaves a frame between the low and high reads to show that the high word is a snapshot. It narrows the per-type counters to 8 bits so that saturation comes within a few hundred events. A long random phase then mixes events, reads of every address, same-cycle read-and-event collisions and rare global clears, and compares each cycle against a behavioural model.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

  localparam int NUM_BKT      = 7;
  localparam int NUM_RX_TYP   = 8;
  localparam int NUM_TX_TYP   = 4;
  localparam int RX_HIST_BASE = NUM_RX_TYP;
  localparam int TX_TYP_BASE  = RX_HIST_BASE + NUM_BKT;
  localparam int TX_HIST_BASE = TX_TYP_BASE + NUM_TX_TYP;
  localparam int NUM_SMALL    = TX_HIST_BASE + NUM_BKT;
  localparam int NUM_PAIR     = 4;

  // receive per-type slots
  localparam int RXT_MCAST = 0;
  localparam int RXT_BCAST = 1;
  localparam int RXT_FCS   = 2;
  localparam int RXT_PAUSE = 3;
  localparam int RXT_JAB   = 4;
  localparam int RXT_SHORT = 5;
  localparam int RXT_SYM   = 6;
  localparam int RXT_OVER  = 7;

  // transmit per-type slots (relative to TX_TYP_BASE)
  localparam int TXT_MCAST = 0;
  localparam int TXT_BCAST = 1;
  localparam int TXT_PAUSE = 2;
  localparam int TXT_ERR   = 3;

  localparam logic [31:0] SHORT_LEN = 32'd64;
  localparam logic [31:0] LONG_LEN  = 32'd1518;

  // upper limit of each histogram bucket except the last
  localparam logic [31:0] BKT_TOP [NUM_BKT-1] =
    '{32'd64, 32'd127, 32'd255, 32'd511, 32'd1023, 32'd1518};

  localparam int ADR_MAXERR = 'h0C;

  function automatic int small_addr(input int i);
    if (i < RX_HIST_BASE)      return 'h04 + i;
    else if (i < TX_TYP_BASE)  return 'h10 + (i - RX_HIST_BASE);
    else if (i < TX_HIST_BASE) return 'h24 + (i - TX_TYP_BASE);
    else                       return 'h30 + (i - TX_HIST_BASE);
  endfunction

  // pair 0: rx bytes, 1: rx frames, 2: tx bytes, 3: tx frames
  function automatic int pair_addr(input int p);
    if (p < 2) return 2 * p;
    else       return 'h20 + 2 * (p - 2);
  endfunction

endpackage

// File: rtl/mac_stat_ctr.sv
module mac_stat_ctr #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             rd_clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     count
);

  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    base   = rd_clr ? '0 : count;
    sum    = {1'b0, base} + (W+1)'(inc);
    cnt_d  = sum[W] ? '1 : sum[W-1:0];
    if (clr_all) cnt_d = '0;
    cnt_en = clr_all | rd_clr | (|inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1 && !clr_all && !rd_clr) |=> (count == '1));

  a_r1_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (count == '0));

  a_r3_read_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !clr_all) |=> (count == W'($past(inc))));

endmodule

// File: rtl/mac_stat_pair.sv
module mac_stat_pair #(
  parameter int W     = 45,
  parameter int INC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             rd_lo,
  input  logic [INC_W-1:0] inc,
  output logic [31:0]      lo_word,
  output logic [31:0]      hi_word
);

  localparam int HI_W = W - 32;

  logic [W-1:0]    cnt;
  logic [HI_W-1:0] shadow_q;
  logic [HI_W-1:0] shadow_d;
  logic            shadow_en;

  mac_stat_ctr #(.W(W), .INC_W(INC_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_all),
    .rd_clr  (rd_lo),
    .inc     (inc),
    .count   (cnt)
  );

  always_comb begin
    shadow_en = clr_all | rd_lo;
    shadow_d  = clr_all ? '0 : cnt[W-1:32];
    lo_word   = cnt[31:0];
    hi_word   = 32'(shadow_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !clr_all) |=> $stable(shadow_q));

endmodule

// File: rtl/mac_stat_class.sv
module mac_stat_class
  import mac_stat_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic [LEN_W-1:0]   len,
  output logic [NUM_BKT-1:0] bucket
);

  logic [31:0] len_x;
  assign len_x = 32'(len);

  for (genvar k = 0; k < NUM_BKT; k++) begin : g_bkt
    if (k == 0) begin : g_first
      assign bucket[k] = (len_x <= BKT_TOP[0]);
    end else if (k == NUM_BKT - 1) begin : g_last
      assign bucket[k] = (len_x > BKT_TOP[k-1]);
    end else begin : g_mid
      assign bucket[k] = (len_x > BKT_TOP[k-1]) && (len_x <= BKT_TOP[k]);
    end
  end

endmodule

// File: rtl/mac_stat_counters.sv
module mac_stat_counters
  import mac_stat_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 45,
  parameter int FRM_W  = 40,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              rx_evt,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_fcs_err,
  input  logic              rx_sym_err,
  input  logic              rx_pause,
  input  logic              rx_mcast,
  input  logic              rx_bcast,
  input  logic [LEN_W-1:0]  max_pkt_len,
  input  logic              rx_fifo_empty,
  input  logic              tx_evt,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              tx_err,
  input  logic              tx_pause,
  input  logic              tx_mcast,
  input  logic              tx_bcast,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);

  localparam int ME_W = CNT_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // frame classification
  logic [NUM_BKT-1:0] rx_bkt, tx_bkt;
  logic               rx_short, rx_long;

  mac_stat_class #(.LEN_W(LEN_W)) u_rx_class (.len(rx_len), .bucket(rx_bkt));
  mac_stat_class #(.LEN_W(LEN_W)) u_tx_class (.len(tx_len), .bucket(tx_bkt));

  assign rx_short = 32'(rx_len) < SHORT_LEN;
  assign rx_long  = 32'(rx_len) > LONG_LEN;

  // increments
  logic [NUM_SMALL-1:0] sm_inc;
  logic [LEN_W-1:0]     pr_inc [NUM_PAIR];
  logic                 me_inc;

  always_comb begin
    sm_inc = '0;
    if (rx_evt) begin
      sm_inc[RXT_MCAST] = rx_mcast;
      sm_inc[RXT_BCAST] = rx_bcast;
      sm_inc[RXT_FCS]   = rx_fcs_err;
      sm_inc[RXT_PAUSE] = rx_pause;
      sm_inc[RXT_JAB]   = rx_long & rx_fcs_err;
      sm_inc[RXT_SHORT] = rx_short;
      sm_inc[RXT_SYM]   = rx_sym_err;
      sm_inc[RXT_OVER]  = rx_long & ~rx_fcs_err;
      sm_inc[RX_HIST_BASE +: NUM_BKT] = rx_bkt;
    end
    if (tx_evt) begin
      sm_inc[TX_TYP_BASE + TXT_MCAST] = tx_mcast;
      sm_inc[TX_TYP_BASE + TXT_BCAST] = tx_bcast;
      sm_inc[TX_TYP_BASE + TXT_PAUSE] = tx_pause;
      sm_inc[TX_TYP_BASE + TXT_ERR]   = tx_err;
      sm_inc[TX_HIST_BASE +: NUM_BKT] = tx_bkt;
    end
    pr_inc[0] = rx_evt ? rx_len : '0;
    pr_inc[1] = LEN_W'(rx_evt);
    pr_inc[2] = tx_evt ? tx_len : '0;
    pr_inc[3] = LEN_W'(tx_evt);
    me_inc    = rx_evt && (rx_len > max_pkt_len);
  end

  // counter storage
  logic [NUM_SMALL-1:0] sm_clr;
  logic [CNT_W-1:0]     sm_cnt [NUM_SMALL];
  logic [NUM_PAIR-1:0]  pr_rd;
  logic [31:0]          pr_lo [NUM_PAIR];
  logic [31:0]          pr_hi [NUM_PAIR];
  logic                 me_clr;
  logic [ME_W-1:0]      me_cnt;

  for (genvar i = 0; i < NUM_SMALL; i++) begin : g_small
    mac_stat_ctr #(.W(CNT_W), .INC_W(1)) u_ctr (
      .clk     (clk),
      .rst_n   (srst_n),
      .clr_all (clr_all),
      .rd_clr  (sm_clr[i]),
      .inc     (sm_inc[i]),
      .count   (sm_cnt[i])
    );
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam int PW = (p % 2 == 0) ? BYTE_W : FRM_W;
    mac_stat_pair #(.W(PW), .INC_W(LEN_W)) u_pair (
      .clk     (clk),
      .rst_n   (srst_n),
      .clr_all (clr_all),
      .rd_lo   (pr_rd[p]),
      .inc     (pr_inc[p]),
      .lo_word (pr_lo[p]),
      .hi_word (pr_hi[p])
    );
  end

  mac_stat_ctr #(.W(ME_W), .INC_W(1)) u_maxerr (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr_all (clr_all),
    .rd_clr  (me_clr),
    .inc     (me_inc),
    .count   (me_cnt)
  );

  // read decode
  logic [31:0] rd_val;
  logic        rd_hit;

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    sm_clr = '0;
    pr_rd  = '0;
    me_clr = 1'b0;
    if (rd_en) begin
      for (int i = 0; i < NUM_SMALL; i++) begin
        if (rd_addr == ADDR_W'(small_addr(i))) begin
          rd_val    = 32'(sm_cnt[i]);
          sm_clr[i] = 1'b1;
          rd_hit    = 1'b1;
        end
      end
      for (int p = 0; p < NUM_PAIR; p++) begin
        if (rd_addr == ADDR_W'(pair_addr(p))) begin
          rd_val   = pr_lo[p];
          pr_rd[p] = 1'b1;
          rd_hit   = 1'b1;
        end
        if (rd_addr == ADDR_W'(pair_addr(p) + 1)) begin
          rd_val = pr_hi[p];
          rd_hit = 1'b1;
        end
      end
      if (rd_addr == ADDR_W'(ADR_MAXERR)) begin
        rd_val = {rx_fifo_empty, 31'(me_cnt)};
        me_clr = 1'b1;
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    rd_data <= '0;
    else if (rd_en) rd_data <= rd_val;
  end

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && !rd_hit) |=> (rd_data == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_en |=> $stable(rd_data));

  a_r6_one_bucket: assert property (@(posedge clk) disable iff (!srst_n)
    rx_evt |-> $onehot(rx_bkt));

  a_r8_empty_flag: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && rd_addr == ADDR_W'(ADR_MAXERR)) |=> (rd_data[31] == $past(rx_fifo_empty)));

endmodule

// File: tb/test_mac_stat_counters.sv
module test_mac_stat_counters;

  localparam int LEN_W  = 24;
  localparam int CNT_W  = 8;
  localparam int BYTE_W = 45;
  localparam int FRM_W  = 40;
  localparam int ADDR_W = 6;
  localparam int NSM    = 26;
  localparam longint SMAX  = (64'd1 << CNT_W) - 1;
  localparam longint MEMAX = (64'd1 << (CNT_W - 1)) - 1;

  logic              clk, rst_n, clr_all;
  logic              rx_evt, rx_fcs_err, rx_sym_err, rx_pause, rx_mcast, rx_bcast, rx_fifo_empty;
  logic [LEN_W-1:0]  rx_len, max_pkt_len, tx_len;
  logic              tx_evt, tx_err, tx_pause, tx_mcast, tx_bcast, rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_data;

  mac_stat_counters #(.LEN_W(LEN_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W),
                      .FRM_W(FRM_W), .ADDR_W(ADDR_W)) i_mac_stat_counters (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .rx_evt(rx_evt), .rx_len(rx_len), .rx_fcs_err(rx_fcs_err), .rx_sym_err(rx_sym_err),
    .rx_pause(rx_pause), .rx_mcast(rx_mcast), .rx_bcast(rx_bcast),
    .max_pkt_len(max_pkt_len), .rx_fifo_empty(rx_fifo_empty),
    .tx_evt(tx_evt), .tx_len(tx_len), .tx_err(tx_err), .tx_pause(tx_pause),
    .tx_mcast(tx_mcast), .tx_bcast(tx_bcast),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural model state
  longint      sm [NSM];
  longint      pc [4];
  longint      sh [4];
  longint      me;
  logic [31:0] exp_rd;
  int          n_vec, n_bad;
  string       cur_req;
  bit          done;

  function automatic longint sat(longint v, longint mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic longint pmax(int p);
    return (p % 2 == 0) ? ((64'd1 << BYTE_W) - 1) : ((64'd1 << FRM_W) - 1);
  endfunction

  function automatic int bkt(int len);
    if (len <= 64)   return 0;
    if (len <= 127)  return 1;
    if (len <= 255)  return 2;
    if (len <= 511)  return 3;
    if (len <= 1023) return 4;
    if (len <= 1518) return 5;
    return 6;
  endfunction

  // word addresses as stated in R2
  function automatic int saddr(int i);
    if (i < 8)  return 'h04 + i;
    if (i < 15) return 'h10 + i - 8;
    if (i < 19) return 'h24 + i - 15;
    return 'h30 + i - 19;
  endfunction

  function automatic int paddr(int p);
    return (p < 2) ? 2 * p : 'h20 + 2 * (p - 2);
  endfunction

  task automatic model_update();
    longint si [NSM];
    longint pinc [4];
    longint mi;
    bit     sc [NSM];
    bit     pr [4];
    bit     mc;
    int     rl, tl, a;
    logic [31:0] v;
    rl = int'(rx_len);
    tl = int'(tx_len);
    mi = 0;
    mc = 0;
    for (int i = 0; i < NSM; i++) begin si[i] = 0; sc[i] = 0; end
    for (int p = 0; p < 4; p++) begin pinc[p] = 0; pr[p] = 0; end
    if (rx_evt) begin
      si[0] = rx_mcast; si[1] = rx_bcast; si[2] = rx_fcs_err; si[3] = rx_pause;
      si[4] = (rl > 1518) && rx_fcs_err;
      si[5] = rl < 64;
      si[6] = rx_sym_err;
      si[7] = (rl > 1518) && !rx_fcs_err;
      si[8 + bkt(rl)] = 1;
      pinc[0] = rl; pinc[1] = 1;
      mi = (rl > int'(max_pkt_len)) ? 1 : 0;
    end
    if (tx_evt) begin
      si[15] = tx_mcast; si[16] = tx_bcast; si[17] = tx_pause; si[18] = tx_err;
      si[19 + bkt(tl)] = 1;
      pinc[2] = tl; pinc[3] = 1;
    end
    if (rd_en) begin
      v = '0;
      a = int'(rd_addr);
      for (int i = 0; i < NSM; i++)
        if (a == saddr(i)) begin v = 32'(sm[i]); sc[i] = 1; end
      for (int p = 0; p < 4; p++) begin
        if (a == paddr(p)) begin v = 32'(pc[p]); pr[p] = 1; end
        if (a == paddr(p) + 1) v = 32'(sh[p]);
      end
      if (a == 'h0C) begin v = {rx_fifo_empty, 31'(me)}; mc = 1; end
      exp_rd = v;
    end
    if (clr_all) begin
      for (int i = 0; i < NSM; i++) sm[i] = 0;
      for (int p = 0; p < 4; p++) begin pc[p] = 0; sh[p] = 0; end
      me = 0;
    end else begin
      for (int i = 0; i < NSM; i++) sm[i] = sat((sc[i] ? 0 : sm[i]) + si[i], SMAX);
      for (int p = 0; p < 4; p++) begin
        if (pr[p]) sh[p] = pc[p] >>> 32;
        pc[p] = sat((pr[p] ? 0 : pc[p]) + pinc[p], pmax(p));
      end
      me = sat((mc ? 0 : me) + mi, MEMAX);
    end
  endtask

  task automatic idle_inputs();
    rx_evt = 0; tx_evt = 0; rd_en = 0; clr_all = 0;
    rx_fcs_err = 0; rx_sym_err = 0; rx_pause = 0; rx_mcast = 0; rx_bcast = 0;
    tx_err = 0; tx_pause = 0; tx_mcast = 0; tx_bcast = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    n_vec++;
    if (rd_data !== exp_rd) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected %h (addr %h)", cur_req, rd_data, exp_rd, rd_addr);
    end
    idle_inputs();
  endtask

  task automatic rx_frame(int len, bit mc, bit bc, bit fcs, bit sym, bit ps);
    rx_evt = 1; rx_len = LEN_W'(len); rx_mcast = mc; rx_bcast = bc;
    rx_fcs_err = fcs; rx_sym_err = sym; rx_pause = ps;
    step();
  endtask

  task automatic tx_frame(int len, bit mc, bit bc, bit er, bit ps);
    tx_evt = 1; tx_len = LEN_W'(len); tx_mcast = mc; tx_bcast = bc;
    tx_err = er; tx_pause = ps;
    step();
  endtask

  task automatic rd(int a);
    rd_en = 1; rd_addr = ADDR_W'(a);
    step();
  endtask

  task automatic read_all();
    for (int a = 0; a < 64; a++) rd(a);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    int lens [15] = '{10, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 9000};
    n_vec = 0; n_bad = 0; done = 0;
    for (int i = 0; i < NSM; i++) sm[i] = 0;
    for (int p = 0; p < 4; p++) begin pc[p] = 0; sh[p] = 0; end
    me = 0; exp_rd = '0;
    rst_n = 0; rx_len = '0; tx_len = '0; rd_addr = '0;
    max_pkt_len = LEN_W'(2000); rx_fifo_empty = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    n_vec++;
    if (rd_data !== 32'h0) begin
      n_bad++; $display("FAIL R1: rd_data=%h expected 00000000 in reset", rd_data);
    end
    rst_n = 1;
    repeat (3) step();

    cur_req = "R1";
    read_all();

    // histogram edges and receive types
    cur_req = "R6";
    for (int k = 0; k < 15; k++)
      rx_frame(lens[k], k[0], k[1], k[2], k[3], k == 5);
    rx_frame(3000, 0, 0, 1, 0, 0);
    cur_req = "R7";
    read_all();

    cur_req = "R9";
    for (int k = 0; k < 15; k++)
      tx_frame(lens[k], k[1], k[0], k[2], k[3]);
    read_all();

    cur_req = "R5";
    rx_frame(1000, 0, 0, 0, 0, 0);
    tx_frame(77, 0, 0, 0, 0);
    rd('h00); rd('h02); rd('h20); rd('h22);

    // max-size error counter and FIFO empty bit
    cur_req = "R8";
    max_pkt_len = LEN_W'(1000);
    rx_frame(999, 0, 0, 0, 0, 0);
    rx_frame(1000, 0, 0, 0, 0, 0);
    rx_frame(1001, 0, 0, 0, 0, 0);
    rx_frame(5000, 0, 0, 1, 0, 0);
    rx_fifo_empty = 1;
    rd('h0C);
    rx_fifo_empty = 0;
    rd('h0C);

    // event in the cycle of the clearing read
    cur_req = "R3";
    rx_frame(100, 1, 0, 0, 0, 0);
    rx_evt = 1; rx_len = LEN_W'(100); rx_mcast = 1; rd_en = 1; rd_addr = ADDR_W'('h04);
    step();
    rd('h04);
    rx_evt = 1; rx_len = LEN_W'(333); rd_en = 1; rd_addr = ADDR_W'('h00);
    step();
    rd('h00);

    // wide pair: high word is a snapshot taken by the low read
    cur_req = "R4";
    clr_all = 1; step();
    for (int k = 0; k < 300; k++) rx_frame(16000000, 0, 0, 0, 0, 0);
    rd('h00);
    rx_frame(5, 0, 0, 0, 0, 0);
    rd('h01);
    rd('h00);
    rd('h01);

    // saturation
    cur_req = "R10";
    max_pkt_len = LEN_W'(1500);
    for (int k = 0; k < 300; k++) rx_frame(1600, 1, 0, 0, 0, 0);
    rd('h04); rd('h0B); rd('h15); rd('h0C);

    // global clear with a colliding event
    cur_req = "R1";
    for (int k = 0; k < 20; k++) tx_frame(200, 1, 1, 1, 1);
    clr_all = 1; tx_evt = 1; tx_len = LEN_W'(60); tx_mcast = 1;
    rx_evt = 1; rx_len = LEN_W'(60);
    step();
    read_all();

    // random mix
    cur_req = "R2";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 1) == 1) begin
        rx_evt = 1;
        rx_len = ($urandom_range(0, 3) == 0) ? LEN_W'($urandom_range(1, 20000))
                                             : LEN_W'($urandom_range(40, 1600));
        rx_mcast = 1'($urandom); rx_bcast = 1'($urandom); rx_fcs_err = 1'($urandom);
        rx_sym_err = 1'($urandom); rx_pause = 1'($urandom);
      end
      if ($urandom_range(0, 1) == 1) begin
        tx_evt = 1;
        tx_len = LEN_W'($urandom_range(40, 2500));
        tx_mcast = 1'($urandom); tx_bcast = 1'($urandom);
        tx_err = 1'($urandom); tx_pause = 1'($urandom);
      end
      rx_fifo_empty = 1'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        rd_en = 1; rd_addr = ADDR_W'($urandom_range(0, 63));
      end
      if ($urandom_range(0, 499) == 0) clr_all = 1;
      cur_req = (k % 2 == 0) ? "R3" : "R2";
      step();
    end
    cur_req = "R5";
    read_all();
    finish_run();
  end

endmodule